// File: doc/BRIEF.md
# Host Serial-Interrupt Enable Register

This block is an 8-bit control register on the local bus of a slave processor. It holds five per-channel enables. Each enable turns an output-buffer-full flag into an interrupt request toward a host over a serialized interrupt link. There are three requests: a keyboard-style request and a mouse-style request, both driven from buffer channel 1, and a system-management request. The system-management request merges three sources: channels 2, 3A and 3B.

Software must read an enable as 0 before it may write it to 1. An enable drops by itself when its buffer-full flag falls. The request for a channel asserts only while its enable and its flag are both high. A direct-mode bit changes this: the requests follow the enables alone, and the system-management enables no longer clear on a flag drop. A read-only flag records whether the most recent stop frame of the link selected quiet or continuous operation. Hardware and software link resets clear the enables and that flag.

Top module: `hsirq_enable_reg`

## Requirements
- R1: After `rst_n` is asserted, every register bit reads 0 and all three requests are 0. The readback layout is:
  - bit 7: quiet flag
  - bit 6: reserved, always 0
  - bit 5: direct mode
  - bit 4: SMI 3B enable
  - bit 3: SMI 3A enable
  - bit 2: SMI 2 enable
  - bit 1: mouse enable
  - bit 0: keyboard enable
- R2: An enable in bits 4..0 becomes 1 only when a write carries 1 in that bit after a read showed the bit as 0. Both of the following leave the bit at 0:
  - a write of 1 with no such read before it;
  - a write of 1 when another write came between the read and that write.
- R3: Writing 0 to an enable clears it. Bit 5 (direct mode) takes the written value directly, with no read needed.
- R4: A pulse on `link_hw_rst` or on `link_sw_rst` clears bits 4..0 and bit 7. Bit 5 keeps its value.
- R5: When buffer flag 1 (`obf_flags[0]`) goes from 1 to 0, the keyboard and mouse enables clear on the next clock edge. This happens in either direct mode.
- R6: A falling edge on `obf_flags[1]`, `obf_flags[2]` or `obf_flags[3]` clears the SMI 2, 3A or 3B enable respectively on the next clock edge. This happens only while direct mode is 0.
- R7: With direct mode 0, each request is its enable ANDed with its buffer flag:
  - keyboard and mouse use `obf_flags[0]`;
  - SMI sources 2, 3A and 3B use `obf_flags[1]`, `obf_flags[2]` and `obf_flags[3]`.

  The request is registered and follows the state with a delay of one clock.
- R8: With direct mode 1, each request equals its enable alone, still delayed by one clock.
- R9: `irq_smi` is the OR of the three gated SMI sources.
- R10: A `stop_evt` pulse loads `stop_quiet` into bit 7 (1 means quiet, 0 means continuous). A link reset in the same cycle wins and leaves 0.
- R11: When a buffer-flag drop and a write of 1 to an armed enable hit the same bit in the same cycle, the enable ends at 0.
- R12: A CPU write does not change bit 7, and bit 6 reads 0 after any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | CPU read strobe, one cycle |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register readback |
| obf_flags | input | 4 | Buffer-full flags: [0] ch1, [1] ch2, [2] ch3A, [3] ch3B |
| link_hw_rst | input | 1 | Link hardware reset pulse |
| link_sw_rst | input | 1 | Link software reset pulse |
| stop_evt | input | 1 | Stop-frame event pulse |
| stop_quiet | input | 1 | Mode carried by the stop frame, 1 = quiet |
| irq_kbd | output | 1 | Keyboard-style request |
| irq_mouse | output | 1 | Mouse-style request |
| irq_smi | output | 1 | Combined system-management request |

## Verification
Two actions can land on the same enable in one cycle: a CPU write of 1 to an armed bit, and the automatic clear caused by the bit's buffer flag dropping. The bench provokes this by reading the keyboard enable as 0 and then driving the write of 1 and the fall of flag 1 on the same clock. It judges the result by the readback: the bit must stay 0, although a lone armed write would set it. An exhaustive sweep then covers both direct modes, all 32 enable patterns and all 16 flag patterns. It checks the readback and the three registered requests one clock after each write.

// File: rtl/hsirq_pkg.sv
package hsirq_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_EN   = 5;
  localparam int NUM_OBF  = 4;
  localparam int NUM_SMI  = 3;
  // bit positions in the readback word
  localparam int B_KBD    = 0;
  localparam int B_MOUSE  = 1;
  localparam int B_SMI0   = 2;
  localparam int B_DIRECT = 5;
  localparam int B_RSVD   = 6;
  localparam int B_QUIET  = 7;
  // buffer flag positions
  localparam int F_CH1    = 0;
  localparam int F_SMI0   = 1;
endpackage

// File: rtl/hsirq_obf_fall.sv
module hsirq_obf_fall #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] obf_in,
  output logic [W-1:0] fall_out
);
  logic [W-1:0] obf_q;
  logic [W-1:0] obf_d;

  always_comb begin
    obf_d = obf_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) obf_q <= '0;
    else        obf_q <= obf_d;
  end

  assign fall_out = obf_q & ~obf_in;
endmodule

// File: rtl/hsirq_en_cell.sv
module hsirq_en_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic link_rst,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic auto_clr,
  output logic en_q
);
  logic armed_q, armed_d, en_d;

  always_comb begin
    armed_d = armed_q;
    en_d    = en_q;
    if (rd_en) armed_d = ~en_q;
    if (wr_en) begin
      armed_d = 1'b0;
      if (!wr_bit)      en_d = 1'b0;
      else if (armed_q) en_d = 1'b1;
    end
    if (auto_clr) en_d = 1'b0;
    if (link_rst) begin
      en_d    = 1'b0;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/hsirq_req_gen.sv
module hsirq_req_gen #(
  parameter int NSMI = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            direct,
  input  logic            en_kbd,
  input  logic            en_mouse,
  input  logic [NSMI-1:0] en_smi,
  input  logic            obf_ch1,
  input  logic [NSMI-1:0] obf_smi,
  output logic            irq_kbd,
  output logic            irq_mouse,
  output logic            irq_smi
);
  logic [NSMI-1:0] smi_src;
  logic kbd_d, mouse_d, smi_d;

  for (genvar i = 0; i < NSMI; i++) begin : g_smi
    assign smi_src[i] = en_smi[i] & (direct | obf_smi[i]);
  end

  always_comb begin
    kbd_d   = en_kbd   & (direct | obf_ch1);
    mouse_d = en_mouse & (direct | obf_ch1);
    smi_d   = |smi_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_kbd   <= 1'b0;
      irq_mouse <= 1'b0;
      irq_smi   <= 1'b0;
    end else begin
      irq_kbd   <= kbd_d;
      irq_mouse <= mouse_d;
      irq_smi   <= smi_d;
    end
  end
endmodule

// File: rtl/hsirq_enable_reg.sv
module hsirq_enable_reg
  import hsirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic [NUM_OBF-1:0] obf_flags,
  input  logic             link_hw_rst,
  input  logic             link_sw_rst,
  input  logic             stop_evt,
  input  logic             stop_quiet,
  output logic             irq_kbd,
  output logic             irq_mouse,
  output logic             irq_smi
);
  logic               link_rst;
  logic [NUM_OBF-1:0] obf_fall;
  logic [NUM_EN-1:0]  en_q;
  logic [NUM_EN-1:0]  auto_clr;
  logic               direct_q, direct_d;
  logic               quiet_q, quiet_d;

  assign link_rst = link_hw_rst | link_sw_rst;

  hsirq_obf_fall #(.W(NUM_OBF)) i_fall (
    .clk(clk), .rst_n(rst_n), .obf_in(obf_flags), .fall_out(obf_fall)
  );

  // channel 1 clears both keyboard and mouse; SMI sources obey direct mode
  always_comb begin
    auto_clr[B_KBD]   = obf_fall[F_CH1];
    auto_clr[B_MOUSE] = obf_fall[F_CH1];
    for (int k = 0; k < NUM_SMI; k++)
      auto_clr[B_SMI0+k] = obf_fall[F_SMI0+k] & ~direct_q;
  end

  for (genvar i = 0; i < NUM_EN; i++) begin : g_en
    hsirq_en_cell i_cell (
      .clk(clk), .rst_n(rst_n), .link_rst(link_rst),
      .rd_en(cpu_rd), .wr_en(cpu_wr), .wr_bit(cpu_wdata[i]),
      .auto_clr(auto_clr[i]), .en_q(en_q[i])
    );
  end

  always_comb begin
    direct_d = direct_q;
    if (cpu_wr) direct_d = cpu_wdata[B_DIRECT];
    quiet_d = quiet_q;
    if (stop_evt) quiet_d = stop_quiet;
    if (link_rst) quiet_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      direct_q <= 1'b0;
      quiet_q  <= 1'b0;
    end else begin
      direct_q <= direct_d;
      quiet_q  <= quiet_d;
    end
  end

  always_comb begin
    cpu_rdata           = '0;
    cpu_rdata[NUM_EN-1:0] = en_q;
    cpu_rdata[B_DIRECT] = direct_q;
    cpu_rdata[B_QUIET]  = quiet_q;
  end

  hsirq_req_gen #(.NSMI(NUM_SMI)) i_req (
    .clk(clk), .rst_n(rst_n), .direct(direct_q),
    .en_kbd(en_q[B_KBD]), .en_mouse(en_q[B_MOUSE]),
    .en_smi(en_q[B_SMI0 +: NUM_SMI]),
    .obf_ch1(obf_flags[F_CH1]), .obf_smi(obf_flags[F_SMI0 +: NUM_SMI]),
    .irq_kbd(irq_kbd), .irq_mouse(irq_mouse), .irq_smi(irq_smi)
  );
endmodule

// File: rtl/hsirq_enable_checker.sv
module hsirq_enable_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_wr,
  input logic [7:0] cpu_wdata,
  input logic [7:0] cpu_rdata,
  input logic [3:0] obf_flags,
  input logic       link_hw_rst,
  input logic       link_sw_rst,
  input logic       stop_evt,
  input logic       stop_quiet,
  input logic       irq_kbd,
  input logic       irq_mouse,
  input logic       irq_smi
);
  assert_set_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rdata[0]) |-> $past(cpu_wr && cpu_wdata[0]));

  assert_link_reset_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_hw_rst || link_sw_rst) |=> (cpu_rdata[4:0] == 5'd0 && !cpu_rdata[7]));

  assert_ch1_fall_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(obf_flags[0]) |=> (cpu_rdata[1:0] == 2'b00));

  assert_direct_keeps_smi2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(obf_flags[1]) && cpu_rdata[5] && !cpu_wr && !link_hw_rst && !link_sw_rst)
    |=> $stable(cpu_rdata[2]));

  assert_kbd_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_kbd == $past(cpu_rdata[0] & (cpu_rdata[5] | obf_flags[0]))));

  assert_smi_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_smi == $past(|(cpu_rdata[4:2] & ({3{cpu_rdata[5]}} | obf_flags[3:1])))));

  assert_quiet_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !link_hw_rst && !link_sw_rst) |=> (cpu_rdata[7] == $past(stop_quiet)));

  assert_mouse_off_without_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdata[1] |=> !irq_mouse);

  always_comb begin
    if (rst_n) assert_reserved_zero_R12: assert (cpu_rdata[6] == 1'b0);
  end
endmodule

bind hsirq_enable_reg hsirq_enable_checker i_checker (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .cpu_rdata(cpu_rdata), .obf_flags(obf_flags), .link_hw_rst(link_hw_rst),
  .link_sw_rst(link_sw_rst), .stop_evt(stop_evt), .stop_quiet(stop_quiet),
  .irq_kbd(irq_kbd), .irq_mouse(irq_mouse), .irq_smi(irq_smi)
);

// File: tb/test_hsirq_enable_reg.sv
module test_hsirq_enable_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [3:0] obf_flags = '0;
  logic link_hw_rst = 1'b0, link_sw_rst = 1'b0;
  logic stop_evt = 1'b0, stop_quiet = 1'b0;
  logic irq_kbd, irq_mouse, irq_smi;
  int n_total = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hsirq_enable_reg i_hsirq_enable_reg (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .obf_flags(obf_flags),
    .link_hw_rst(link_hw_rst), .link_sw_rst(link_sw_rst),
    .stop_evt(stop_evt), .stop_quiet(stop_quiet),
    .irq_kbd(irq_kbd), .irq_mouse(irq_mouse), .irq_smi(irq_smi)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_read();
    cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
  endtask

  task automatic do_write(logic [7:0] d);
    cpu_wr = 1'b1; cpu_wdata = d; tick(); cpu_wr = 1'b0; cpu_wdata = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    check("R1 reset readback", cpu_rdata, 8'h00);
    check("R1 reset requests", {5'd0, irq_kbd, irq_mouse, irq_smi}, 8'h00);
    rst_n = 1'b1;
    tick();

    // R2 write 1 without prior read has no effect
    do_write(8'h1F);
    check("R2 unarmed write", cpu_rdata, 8'h00);
    // R2 read then write 1 sets
    do_read(); do_write(8'h01);
    check("R2 armed write", cpu_rdata, 8'h01);
    // R2 intervening write disarms
    do_read(); do_write(8'h01); do_write(8'h03);
    check("R2 disarmed by write", cpu_rdata, 8'h01);
    // R3 write 0 clears; direct bit written plainly
    do_write(8'h20);
    check("R3 clear and direct", cpu_rdata, 8'h20);
    // R12 bit 7 and bit 6 untouched by write
    do_read(); do_write(8'hFF);
    check("R12 readonly bits", cpu_rdata, 8'h3F);

    // R10 stop frame
    stop_evt = 1'b1; stop_quiet = 1'b1; tick(); stop_evt = 1'b0;
    check("R10 quiet load", cpu_rdata, 8'hBF);
    // R4 hardware link reset
    link_hw_rst = 1'b1; tick(); link_hw_rst = 1'b0;
    check("R4 hw link reset", cpu_rdata, 8'h20);
    do_read(); do_write(8'h3F);
    stop_evt = 1'b1; stop_quiet = 1'b1; tick(); stop_evt = 1'b0;
    // R4/R10 software reset wins over a same-cycle stop event
    link_sw_rst = 1'b1; stop_evt = 1'b1; tick();
    link_sw_rst = 1'b0; stop_evt = 1'b0;
    check("R4 sw link reset beats stop R10", cpu_rdata, 8'h20);
    stop_evt = 1'b1; stop_quiet = 1'b0; tick(); stop_evt = 1'b0;
    check("R10 continuous load", cpu_rdata, 8'h20);

    // R5 channel 1 drop clears kbd and mouse even in direct mode
    obf_flags = 4'hF; tick();
    do_read(); do_write(8'h3F);
    obf_flags[0] = 1'b0;
    check("R5 before edge", cpu_rdata, 8'h3F);
    tick();
    check("R5 after edge direct=1", cpu_rdata, 8'h3C);
    // R6 direct=1: SMI enables survive their flag drops
    obf_flags[3:1] = 3'b000; tick();
    check("R6 direct keeps smi", cpu_rdata, 8'h3C);
    // R6 direct=0: own flag drop clears only its own enable
    obf_flags = 4'hF; tick();
    do_write(8'h1C);
    obf_flags[2] = 1'b0; tick();
    check("R6 3A cleared", cpu_rdata, 8'h14);
    obf_flags[1] = 1'b0; tick();
    check("R6 2 cleared", cpu_rdata, 8'h10);

    // R11 same-cycle armed write and flag drop
    do_write(8'h00);
    obf_flags = 4'hF; tick();
    do_read();
    cpu_wr = 1'b1; cpu_wdata = 8'h01; obf_flags[0] = 1'b0; tick();
    cpu_wr = 1'b0; cpu_wdata = '0;
    check("R11 clear beats write", cpu_rdata, 8'h00);

    // R7 R8 R9 exhaustive sweep
    for (int dir = 0; dir < 2; dir++) begin
      for (int m = 0; m < 32; m++) begin
        for (int f = 0; f < 16; f++) begin
          logic [7:0] exp_rd;
          logic ek, em, es;
          logic [2:0] g;
          obf_flags = f[3:0]; tick();
          do_read(); do_write({2'b00, dir[0], m[4:0]});
          exp_rd = {2'b00, dir[0], m[4:0]};
          check("R3 sweep readback", cpu_rdata, exp_rd);
          tick();
          ek = m[0] & (dir[0] | f[0]);
          em = m[1] & (dir[0] | f[0]);
          g  = m[4:2] & ({3{dir[0]}} | f[3:1]);
          es = |g;
          if (dir == 0) check("R7 gated requests", {5'd0, irq_kbd, irq_mouse, irq_smi}, {5'd0, ek, em, es});
          else          check("R8 direct requests", {5'd0, irq_kbd, irq_mouse, irq_smi}, {5'd0, ek, em, es});
          check("R9 smi or", {7'd0, irq_smi}, {7'd0, es});
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule